// File: doc/BRIEF.md
# Programmable TFT Panel Timing Generator

This block produces the raster timing for a parallel TFT panel: a pixel clock, horizontal and vertical sync, a data-enable strobe, the current pixel coordinates and a per-pixel strobe. A small register file configures it. The register file holds the active size, the horizontal and vertical porch and pulse lengths, and a panel word. The panel word carries the pixel divider, the polarity of every panel signal and the pixel source. The porch and pulse fields are stored with fixed offsets. Horizontal front porch and pulse width are stored minus one, horizontal back porch minus three, and the vertical fields are stored as-is. The block adds these offsets back when it counts.

Each line runs through its active pixels, then the front porch, then the sync pulse, then the back porch. The line counter steps once per completed line and follows the same order. An end-of-frame event sets a status bit that can drive an interrupt line. The block has no enable bit. The counters are held at the first pixel while `pclk_run` is low and start as soon as it goes high, so configuration is written while `pclk_run` is low. Pixel data is either a coordinate test pattern or the `pix_in` word, passed through.

Top module: `lcdt_top`

## Requirements
- R1: After reset, every configuration register and the status bit read as 0. The sync, data-enable, data and interrupt outputs are 0.
- R2: Word addresses 0 (size), 1 (horizontal), 2 (vertical), 3 (panel) and 4 (interrupt enable) read back the 32-bit value last written. Read data appears the cycle after `reg_rd`.
- R3: `pix_stb` pulses once every D clocks, where D is panel bits 5:0 plus one.
- R4: Within each pixel period, `lcd_pclk` is high for the first ceil(D/2) clocks and low for the rest. Panel bit 21 set inverts it.
- R5: Active width is 16 times size bits 26:20, clamped to 64..1024. Horizontal front porch is bits 15:8 + 1, sync is bits 31:26 + 1 and back porch is bits 7:0 + 3, all in pixel periods.
- R6: Active height is size bits 10:0, clamped to 64..1024. The vertical register uses the same field positions as the horizontal one, in lines, with no offset.
- R7: Data enable is active only when both axes are in their active region. It never overlaps horizontal sync.
- R8: Panel bits 20 (data enable), 22 (hsync), 23 (vsync) and 24 (pixel data) set make that output active low, that is, inverted.
- R9: Panel bit 12 set outputs the pattern {y[7:0], x[7:0]}; clear, it outputs `pix_in`. Outside data enable the word is 0 before polarity.
- R10: Status bit 1 (address 5) sets when the last pixel of a frame completes. `irq` is status AND enable bit 1, registered. It rises in the same cycle that pixel (0,0) of the next frame appears.
- R11: Writing 1 to status bit 1 clears it, and writing 0 leaves it set. A new end of frame in the same cycle wins.
- R12: While `pclk_run` is low, the counters sit at pixel (0,0) and every output is inactive. One clock after `pclk_run` rises, pixel (0,0) is shown with data enable active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| pclk_run | input | 1 | Pixel clock gate; low holds the raster at its start |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | AW | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| pix_in | input | PIX_W | Pass-through pixel word |
| pix_stb | output | 1 | One pulse per pixel period |
| lcd_pclk | output | 1 | Pixel clock after polarity |
| lcd_hsync | output | 1 | Horizontal sync after polarity |
| lcd_vsync | output | 1 | Vertical sync after polarity |
| lcd_de | output | 1 | Data enable after polarity |
| lcd_data | output | PIX_W | Pixel data after polarity |
| pos_x | output | 12 | Current column counter |
| pos_y | output | 12 | Current line counter |
| irq | output | 1 | End-of-frame interrupt |

## Verification
On every cycle, the assertions check the following. Data enable and horizontal sync never overlap. A gated raster keeps data enable and hsync inactive. The interrupt only rises with the enable set. An end of frame always sets the status bit, and a write-one clear without a competing frame end always drops it. The bench scenarios are the only place where the exact lengths of each region in pixels and lines are shown, together with the offset decoding and width clamping, the divider and pixel clock duty, the pattern contents and the cycle in which the interrupt rises.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;
  // position counter width, covers the longest line or frame
  localparam int POS_W = 12;
  localparam int REG_W = 32;

  // register word addresses
  localparam int A_SIZE  = 0;
  localparam int A_HCFG  = 1;
  localparam int A_VCFG  = 2;
  localparam int A_PANEL = 3;
  localparam int A_IEN   = 4;
  localparam int A_ISTAT = 5;

  localparam int EOF_BIT = 1;

  // panel word bit positions
  localparam int P_PAT      = 12;
  localparam int P_DE_POL   = 20;
  localparam int P_PCLK_POL = 21;
  localparam int P_HS_POL   = 22;
  localparam int P_VS_POL   = 23;
  localparam int P_DAT_POL  = 24;

  // decoded lengths of one axis, all in units of steps
  typedef struct packed {
    logic [POS_W-1:0] len;
    logic [POS_W-1:0] fp;
    logic [POS_W-1:0] sw;
    logic [POS_W-1:0] bp;
  } axis_cfg_t;
endpackage

// File: rtl/lcdt_pixdiv.sv
module lcdt_pixdiv #(
  parameter int DW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [DW-1:0] pcd,
  output logic          ce,
  output logic          phase
);
  logic [DW-1:0] cnt_q;
  logic [DW:0]   half;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else if (cnt_q >= pcd) cnt_q <= '0;
    else cnt_q <= cnt_q + DW'(1);
  end

  always_comb begin
    half  = ({1'b0, pcd} + (DW+1)'(2)) >> 1;
    ce    = run && (cnt_q >= pcd);
    phase = run && ({1'b0, cnt_q} < half);
  end
endmodule

// File: rtl/lcdt_axis.sv
module lcdt_axis import lcdt_pkg::*; (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             step,
  input  axis_cfg_t        cfg,
  output logic [POS_W-1:0] pos,
  output logic             active,
  output logic             sync,
  output logic             last
);
  logic [POS_W-1:0] s0, s1, tot_m1;

  always_comb begin
    s0     = cfg.len + cfg.fp;
    s1     = s0 + cfg.sw;
    tot_m1 = s1 + cfg.bp - POS_W'(1);
    active = pos < cfg.len;
    sync   = (pos >= s0) && (pos < s1);
    last   = pos == tot_m1;
  end

  always_ff @(posedge clk) begin
    if (rst || !run) pos <= '0;
    else if (step) pos <= last ? '0 : pos + POS_W'(1);
  end
endmodule

// File: rtl/lcdt_regs.sv
module lcdt_regs import lcdt_pkg::*; #(
  parameter int AW = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [AW-1:0]    addr,
  input  logic [REG_W-1:0] wdata,
  input  logic             eof,
  output logic [REG_W-1:0] size_q,
  output logic [REG_W-1:0] hcfg_q,
  output logic [REG_W-1:0] vcfg_q,
  output logic [REG_W-1:0] panel_q,
  output logic [REG_W-1:0] ien_q,
  output logic             stat_q,
  output logic             irq_q,
  output logic [REG_W-1:0] rdata_q
);
  logic [REG_W-1:0] rd_mux;
  logic             clr_req;

  always_comb begin
    rd_mux = '0;
    case (addr)
      AW'(A_SIZE):  rd_mux = size_q;
      AW'(A_HCFG):  rd_mux = hcfg_q;
      AW'(A_VCFG):  rd_mux = vcfg_q;
      AW'(A_PANEL): rd_mux = panel_q;
      AW'(A_IEN):   rd_mux = ien_q;
      AW'(A_ISTAT): rd_mux[EOF_BIT] = stat_q;
      default:      rd_mux = '0;
    endcase
    clr_req = wr_en && (addr == AW'(A_ISTAT)) && wdata[EOF_BIT];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      size_q  <= '0;
      hcfg_q  <= '0;
      vcfg_q  <= '0;
      panel_q <= '0;
      ien_q   <= '0;
      stat_q  <= 1'b0;
      irq_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (wr_en) begin
        case (addr)
          AW'(A_SIZE):  size_q  <= wdata;
          AW'(A_HCFG):  hcfg_q  <= wdata;
          AW'(A_VCFG):  vcfg_q  <= wdata;
          AW'(A_PANEL): panel_q <= wdata;
          AW'(A_IEN):   ien_q   <= wdata;
          default: ;
        endcase
      end
      if (eof) stat_q <= 1'b1;
      else if (clr_req) stat_q <= 1'b0;
      irq_q <= stat_q & ien_q[EOF_BIT];
      if (rd_en) rdata_q <= rd_mux;
    end
  end
endmodule

// File: rtl/lcdt_top.sv
module lcdt_top import lcdt_pkg::*; #(
  parameter int PIX_W   = 16,
  parameter int MIN_RES = 64,
  parameter int MAX_RES = 1024,
  parameter int AW      = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pclk_run,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [AW-1:0]    reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic [PIX_W-1:0] pix_in,
  output logic             pix_stb,
  output logic             lcd_pclk,
  output logic             lcd_hsync,
  output logic             lcd_vsync,
  output logic             lcd_de,
  output logic [PIX_W-1:0] lcd_data,
  output logic [POS_W-1:0] pos_x,
  output logic [POS_W-1:0] pos_y,
  output logic             irq
);
  localparam int RES_W  = $clog2(MAX_RES) + 1;
  localparam int UNIT_W = RES_W - 4;
  localparam int HALF_W = PIX_W / 2;
  localparam int DIV_W  = 6;
  localparam logic [RES_W-1:0] RES_LO = RES_W'(MIN_RES);
  localparam logic [RES_W-1:0] RES_HI = RES_W'(MAX_RES);

  logic [REG_W-1:0] size_q, hcfg_q, vcfg_q, panel_q, ien_q;
  logic             stat_q, eof, pix_ce, phase;
  logic             h_act, h_sync, h_last, v_act, v_sync, v_last, de_raw;
  logic [POS_W-1:0] hpos, vpos;
  axis_cfg_t        hcfg, vcfg;
  logic [PIX_W-1:0] pattern, pix_sel;
  logic             de_pol, hs_pol, vs_pol, unused_bits;

  function automatic logic [POS_W-1:0] clamp_res(input logic [RES_W-1:0] v);
    if (v < RES_LO) return POS_W'(RES_LO);
    if (v > RES_HI) return POS_W'(RES_HI);
    return POS_W'(v);
  endfunction

  lcdt_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .rd_en(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .eof(eof), .size_q(size_q), .hcfg_q(hcfg_q),
    .vcfg_q(vcfg_q), .panel_q(panel_q), .ien_q(ien_q), .stat_q(stat_q),
    .irq_q(irq), .rdata_q(reg_rdata)
  );

  lcdt_pixdiv #(.DW(DIV_W)) u_div (
    .clk(clk), .rst(rst), .run(pclk_run), .pcd(panel_q[DIV_W-1:0]),
    .ce(pix_ce), .phase(phase)
  );

  // field decode with the stored offsets added back
  always_comb begin
    hcfg.len = clamp_res({size_q[20 +: UNIT_W], 4'b0000});
    hcfg.fp  = POS_W'(hcfg_q[15:8])  + POS_W'(1);
    hcfg.sw  = POS_W'(hcfg_q[31:26]) + POS_W'(1);
    hcfg.bp  = POS_W'(hcfg_q[7:0])   + POS_W'(3);
    vcfg.len = clamp_res(size_q[RES_W-1:0]);
    vcfg.fp  = POS_W'(vcfg_q[15:8]);
    vcfg.sw  = POS_W'(vcfg_q[31:26]);
    vcfg.bp  = POS_W'(vcfg_q[7:0]);
  end

  lcdt_axis u_hax (
    .clk(clk), .rst(rst), .run(pclk_run), .step(pix_ce), .cfg(hcfg),
    .pos(hpos), .active(h_act), .sync(h_sync), .last(h_last)
  );

  lcdt_axis u_vax (
    .clk(clk), .rst(rst), .run(pclk_run), .step(pix_ce && h_last), .cfg(vcfg),
    .pos(vpos), .active(v_act), .sync(v_sync), .last(v_last)
  );

  always_comb begin
    eof     = pix_ce && h_last && v_last;
    de_raw  = pclk_run && h_act && v_act;
    de_pol  = panel_q[P_DE_POL];
    hs_pol  = panel_q[P_HS_POL];
    vs_pol  = panel_q[P_VS_POL];
    pattern = {vpos[HALF_W-1:0], hpos[HALF_W-1:0]};
    pix_sel = panel_q[P_PAT] ? pattern : pix_in;
    unused_bits = ^{size_q[31:20+UNIT_W], size_q[19:RES_W], hcfg_q[25:16],
                    vcfg_q[25:16], panel_q[31:25], panel_q[19:13],
                    panel_q[11:DIV_W], ien_q[31:2], ien_q[0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_stb   <= 1'b0;
      lcd_pclk  <= 1'b0;
      lcd_hsync <= 1'b0;
      lcd_vsync <= 1'b0;
      lcd_de    <= 1'b0;
      lcd_data  <= '0;
      pos_x     <= '0;
      pos_y     <= '0;
    end else begin
      pix_stb   <= pix_ce;
      lcd_pclk  <= phase ^ panel_q[P_PCLK_POL];
      lcd_hsync <= (pclk_run && h_sync) ^ hs_pol;
      lcd_vsync <= (pclk_run && v_sync) ^ vs_pol;
      lcd_de    <= de_raw ^ de_pol;
      lcd_data  <= (de_raw ? pix_sel : '0) ^ {PIX_W{panel_q[P_DAT_POL]}};
      pos_x     <= hpos;
      pos_y     <= vpos;
    end
  end
endmodule

// File: rtl/lcdt_chk.sv
module lcdt_chk #(
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          pclk_run,
  input logic          lcd_de,
  input logic          lcd_hsync,
  input logic          de_pol,
  input logic          hs_pol,
  input logic          irq,
  input logic          ien_bit,
  input logic          stat_q,
  input logic          eof,
  input logic          reg_wr,
  input logic [AW-1:0] reg_addr,
  input logic          wbit
);
  AST_DE_HSYNC_APART: assert property (@(posedge clk) disable iff (rst)
    (lcd_de ^ $past(de_pol)) |-> !(lcd_hsync ^ $past(hs_pol))); // R7

  AST_GATED_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(!pclk_run) |-> ((lcd_de == $past(de_pol)) && (lcd_hsync == $past(hs_pol)))); // R12

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(ien_bit)); // R10

  AST_EOF_SETS_STATUS: assert property (@(posedge clk) disable iff (rst)
    eof |=> stat_q); // R10

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && (reg_addr == AW'(5)) && wbit && !eof) |=> !stat_q); // R11
endmodule

bind lcdt_top lcdt_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .pclk_run(pclk_run), .lcd_de(lcd_de),
  .lcd_hsync(lcd_hsync), .de_pol(de_pol), .hs_pol(hs_pol), .irq(irq),
  .ien_bit(ien_q[1]), .stat_q(stat_q), .eof(eof), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .wbit(reg_wdata[1])
);

// File: tb/test_lcdt_top.sv
module test_lcdt_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run = 1'b0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [15:0] pix_in = '0;
  logic        stb, pclk, hs, vs, de, irq;
  logic [15:0] data;
  logic [11:0] px, py;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  localparam logic [31:0] H_STD  = (32'd2 << 26) | (32'd1 << 8);
  localparam logic [31:0] V_STD  = (32'd2 << 26) | (32'd1 << 8) | 32'd3;
  localparam logic [31:0] SZ_STD = (32'd4 << 20) | 32'd64;
  localparam logic [31:0] ALLPOL = (32'd1 << 20) | (32'd1 << 21) | (32'd1 << 22)
                                 | (32'd1 << 23) | (32'd1 << 24);

  always #5 clk = ~clk;

  lcdt_top i_lcdt_top (
    .clk(clk), .rst(rst), .pclk_run(run), .reg_wr(wr), .reg_rd(rd),
    .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata), .pix_in(pix_in),
    .pix_stb(stb), .lcd_pclk(pclk), .lcd_hsync(hs), .lcd_vsync(vs),
    .lcd_de(de), .lcd_data(data), .pos_x(px), .pos_y(py), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wreg(input int a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = 3'(a); wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rreg(input int a, output logic [31:0] d);
    @(negedge clk);
    rd = 1'b1; addr = 3'(a);
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  function automatic logic sig(input int sel);
    case (sel)
      0: return de;
      1: return hs;
      2: return vs;
      3: return irq;
      default: return pclk;
    endcase
  endfunction

  task automatic run_len(input int sel, input logic lvl, input int limit, output int n);
    n = 0;
    while (sig(sel) == lvl && n < limit) begin
      n++;
      @(negedge clk);
    end
  endtask

  // gate off, program, clear status, gate on; returns at the first pixel
  task automatic configure(input logic [31:0] sz, input logic [31:0] h,
                           input logic [31:0] v, input logic [31:0] pnl);
    @(negedge clk);
    run = 1'b0;
    wreg(0, sz); wreg(1, h); wreg(2, v); wreg(3, pnl); wreg(5, 32'd2);
    @(negedge clk);
    run = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 de", int'(de), 0);
    chk("R1 hsync", int'(hs), 0);
    chk("R1 vsync", int'(vs), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 data", int'(data), 0);
    for (int a = 0; a < 6; a++) begin
      rreg(a, d);
      chk("R1 register", int'(d), 0);
    end
  endtask

  task automatic t_regs();
    logic [31:0] d;
    logic [31:0] vals [5];
    vals[0] = 32'h0460_0050; vals[1] = 32'hA400_1234; vals[2] = 32'h1C00_0507;
    vals[3] = 32'h0A00_1003; vals[4] = 32'hFFFF_FFFF;
    for (int a = 0; a < 5; a++) wreg(a, vals[a]);
    for (int a = 0; a < 5; a++) begin
      rreg(a, d);
      chk("R2 readback", int'(d), int'(vals[a]));
    end
    wreg(4, 32'd0);
  endtask

  task automatic t_gate();
    configure(SZ_STD, H_STD, V_STD, 32'd0);
    chk("R12 first de", int'(de), 1);
    chk("R12 first x", int'(px), 0);
    chk("R12 first y", int'(py), 0);
    repeat (5) @(negedge clk);
    chk("R12 x after 5", int'(px), 5);
    run = 1'b0;
    @(negedge clk);
    chk("R12 de gated", int'(de), 0);
    chk("R12 hsync gated", int'(hs), 0);
  endtask

  task automatic t_hline();
    int n;
    configure(SZ_STD, H_STD, V_STD, 32'd0);
    run_len(0, 1'b1, 4000, n); chk("R5 active", n, 64);
    run_len(1, 1'b0, 4000, n); chk("R5 front porch", n, 2);
    run_len(1, 1'b1, 4000, n); chk("R5 sync", n, 3);
    run_len(0, 1'b0, 4000, n); chk("R5 back porch", n, 3);
  endtask

  task automatic t_div();
    int n, hi, pulses;
    configure(SZ_STD, H_STD, V_STD, 32'd2);
    run_len(0, 1'b1, 4000, n); chk("R3 active at div3", n, 192);
    run_len(1, 1'b0, 4000, n); chk("R3 front porch at div3", n, 6);
    hi = 0; pulses = 0;
    for (int i = 0; i < 300; i++) begin
      pulses += int'(stb);
      hi += int'(pclk);
      @(negedge clk);
    end
    chk("R3 strobe count", pulses, 100);
    chk("R4 pclk high count", hi, 200);
    configure(SZ_STD, H_STD, V_STD, 32'd2 | (32'd1 << 21));
    hi = 0;
    for (int i = 0; i < 300; i++) begin
      hi += int'(pclk);
      @(negedge clk);
    end
    chk("R4 pclk inverted high count", hi, 100);
  endtask

  task automatic t_vert();
    int n;
    configure(SZ_STD, H_STD, V_STD, 32'd0);
    run_len(2, 1'b0, 20000, n); chk("R6 lines before vsync", n, 65 * 72);
    run_len(2, 1'b1, 20000, n); chk("R6 vsync length", n, 2 * 72);
    run_len(0, 1'b0, 20000, n); chk("R6 back porch", n, 3 * 72);
  endtask

  task automatic t_clamp();
    int n;
    configure(32'd64, H_STD, V_STD, 32'd0);
    run_len(0, 1'b1, 4000, n); chk("R5 width clamp low", n, 64);
    configure((32'd100 << 20) | 32'd64, H_STD, V_STD, 32'd0);
    run_len(0, 1'b1, 4000, n); chk("R5 width clamp high", n, 1024);
    configure(32'd4 << 20, H_STD, V_STD, 32'd0);
    run_len(2, 1'b0, 20000, n); chk("R6 height clamp low", n, 65 * 72);
  endtask

  task automatic t_pol();
    @(negedge clk);
    run = 1'b0;
    wreg(3, ALLPOL);
    @(negedge clk);
    chk("R8 idle hsync", int'(hs), 1);
    chk("R8 idle vsync", int'(vs), 1);
    chk("R8 idle de", int'(de), 1);
    chk("R8 idle pclk", int'(pclk), 1);
    chk("R8 idle data", int'(data), 16'hFFFF);
    pix_in = 16'h1234;
    configure(SZ_STD, H_STD, V_STD, ALLPOL);
    chk("R8 active de low", int'(de), 0);
    chk("R8 inverted data", int'(data), 16'hEDCB);
    chk("R8 hsync inactive high", int'(hs), 1);
    chk("R8 pclk inverted", int'(pclk), 0);
  endtask

  task automatic t_pattern();
    configure(SZ_STD, H_STD, V_STD, 32'd1 << 12);
    for (int i = 0; i < 10; i++) begin
      chk("R9 pattern x", int'(px), i);
      chk("R9 pattern word", int'(data), int'({py[7:0], px[7:0]}));
      @(negedge clk);
    end
    repeat (67) @(negedge clk);
    chk("R9 pattern line1 x", int'(px), 5);
    chk("R9 pattern line1 y", int'(py), 1);
    chk("R9 pattern line1 word", int'(data), 16'h0105);
  endtask

  task automatic t_pass();
    pix_in = 16'hA5C3;
    configure(SZ_STD, H_STD, V_STD, 32'd0);
    chk("R9 pass-through", int'(data), 16'hA5C3);
    repeat (64) @(negedge clk);
    chk("R7 de off in front porch", int'(de), 0);
    chk("R9 blank data", int'(data), 0);
  endtask

  task automatic t_eof();
    int n;
    logic [31:0] d;
    configure(SZ_STD, H_STD, V_STD, 32'd0);
    wreg(4, 32'd2);
    run_len(3, 1'b0, 20000, n);
    chk("R10 irq rise cycle", n, 5038);
    chk("R10 irq with first pixel de", int'(de), 1);
    chk("R10 irq with x 0", int'(px), 0);
    chk("R10 irq with y 0", int'(py), 0);
    rreg(5, d); chk("R10 status set", int'(d), 2);
    wreg(5, 32'd0);
    rreg(5, d); chk("R11 write 0 keeps", int'(d), 2);
    wreg(5, 32'd2);
    @(negedge clk);
    chk("R11 irq drops", int'(irq), 0);
    rreg(5, d); chk("R11 status cleared", int'(d), 0);
    wreg(4, 32'd0);
    run_len(3, 1'b0, 5200, n);
    chk("R10 no irq when disabled", n, 5200);
    rreg(5, d); chk("R10 status sets while disabled", int'(d), 2);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regs();
    t_gate();
    t_hline();
    t_div();
    t_vert();
    t_clamp();
    t_pol();
    t_pattern();
    t_pass();
    t_eof();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule